// File: doc/BRIEF.md
# Serial Link Root-Port Bring-Up Sequencer

This block takes a serial link controller out of reset-time defaults and into root-port operation, then watches for the link to train. A single `start` pulse begins the sequence. The block issues a fixed series of register accesses through a simple read/write port into the controller. Most of these accesses are read-modify-write operations that change one field and keep every other bit. During the sequence it:

- switches link training off if the link is not already up;
- selects root-complex device type;
- loads the bus cache attributes;
- programs the requested link speed into the speed-control and capability fields;
- disables the long equalization evaluation phase;
- re-enables training if the link is still down.

After the configuration writes, the block polls a status word from the controller. The link counts as up only when two status bits are set at once. Polling is bounded by a millisecond-tick timeout. Once the link is up, a microsecond-tick settle delay runs before completion is reported.

The outcome stays on `done`, `link_up` and `timeout` until the next accepted `start`. Both tick inputs come from outside the block, so the integrator sets the time base.

Top module: `lnk_bringup_seq`

## Requirements
- R1: After reset, `done`, `link_up` and `timeout` are 0, and no access is made on the register port until `start` is seen.
- R2: The link counts as up only when `link_status` bit 1 (data link up) and bit 9 (physical link up) are both 1. Either bit alone does not end the poll.
- R3: If the link is not up when the sequence begins, the first write goes to address 0x8000 with bit 2 (training enable) cleared and all other bits as read. If the link is up, this write is skipped.
- R4: Bits 7:4 of address 0x8000 are written with code 4 (root complex; 0 is endpoint, 1 is legacy endpoint). All other bits keep their read value.
- R5: Address 0x8050 is written with 0x00003511 and address 0x8054 with 0x00005311. These are plain writes, with no read first.
- R6: Bits 3:0 of address 0x00A0 and of address 0x007C take the speed code (1, 2 or 3) captured at `start`. Bits 31:4 keep their read values.
- R7: Bit 5 of address 0x08A8 is set and all other bits are kept.
- R8: After R7, if the link is still down, address 0x8000 is written with bit 2 set and all other bits as read. If the link is up, this write is skipped.
- R9: If the link is not up by the TIMEOUT_MS-th `tick_ms` pulse (default 100) counted in the poll phase, the next cycle shows `done`=1, `timeout`=1 and `link_up`=0.
- R10: Once the link is seen up, the block counts SETTLE_US `tick_us` pulses (default 100). The cycle after the last pulse shows `done`=1, `link_up`=1 and `timeout`=0. Before that pulse, `done` stays 0.
- R11: A `start` while a sequence is running is ignored. The outcome outputs hold until the next accepted `start`, which clears them the following cycle.
- R12: Writes occur only in this order: R3, R4, R5 (0x8050 then 0x8054), R6 (0x00A0 then 0x007C), R7, R8. Each read-modify-write reads its address before writing it, and read data must be valid one cycle after `cfg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (accepted only when idle) |
| speed_code | input | 4 | Requested link speed code, captured at start |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| link_status | input | 32 | Controller global status word |
| cfg_rd_en | output | 1 | Register read request |
| cfg_wr_en | output | 1 | Register write strobe |
| cfg_addr | output | 16 | Register address |
| cfg_wdata | output | 32 | Register write data |
| cfg_rdata | input | 32 | Register read data, valid the cycle after the request |
| done | output | 1 | Sequence finished (held until next start) |
| link_up | output | 1 | Finished with link trained |
| timeout | output | 1 | Finished without link within the timeout |

## Verification
The hardest situations to reach are the poll phase ending on a single status bit, and a second `start` arriving mid-sequence. Both depend on the bench holding the status word and tick pulses exactly where it wants while the configuration writes run. The bench keeps `link_status` fixed during the writes. It then waits until its scoreboard has drained, which shows the block is polling, and only then drives one status bit, a stray `start` and counted tick pulses. A register model answers every read with preloaded patterns that have the surrounding bits set. This makes any read-modify-write that drops neighbouring bits show up as a mismatched write.

// File: rtl/lnk_bringup_pkg.sv
// Package: shared constants, types and the per-step register operation table
// for the link bring-up sequencer. Addresses and bit positions are those the
// controller decodes, so they are fixed here rather than parameterized.
package lnk_bringup_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int SPEED_W   = 4;

    typedef logic [ADDR_W-1:0] reg_addr_t;
    typedef logic [DATA_W-1:0] reg_data_t;

    // Controller register addresses
    localparam reg_addr_t GCTL_ADDR   = 16'h8000;
    localparam reg_addr_t RCACHE_ADDR = 16'h8050;
    localparam reg_addr_t WCACHE_ADDR = 16'h8054;
    localparam reg_addr_t LCTL2_ADDR  = 16'h00A0;
    localparam reg_addr_t LCAP_ADDR   = 16'h007C;
    localparam reg_addr_t EQCTL_ADDR  = 16'h08A8;

    // Field positions and values
    localparam int TRAIN_EN_BIT    = 2;
    localparam int DEVTYPE_LSB     = 4;
    localparam int DEVTYPE_W       = 4;
    localparam int DEVTYPE_ROOT    = 4;
    localparam int EQ_EVAL_OFF_BIT = 5;
    localparam int STS_DL_BIT      = 1;
    localparam int STS_PHY_BIT     = 9;
    localparam reg_data_t RCACHE_VAL = 32'h0000_3511;
    localparam reg_data_t WCACHE_VAL = 32'h0000_5311;

    // One register operation: write (old & ~mask) | (val & mask)
    typedef struct packed {
        reg_addr_t addr;
        reg_data_t mask;
        reg_data_t val;
        logic      rmw;
    } reg_op_t;

    typedef enum logic [2:0] {
        STEP_TRAIN_OFF = 3'd0,
        STEP_DEVTYPE   = 3'd1,
        STEP_RCACHE    = 3'd2,
        STEP_WCACHE    = 3'd3,
        STEP_LCTL2     = 3'd4,
        STEP_LCAP      = 3'd5,
        STEP_EQ        = 3'd6,
        STEP_TRAIN_ON  = 3'd7
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_POLL, ST_SETTLE
    } seq_state_t;

    typedef enum logic [1:0] {
        P_IDLE, P_READ, P_CAPT, P_WRITE
    } port_state_t;

    // Build the register operation for one sequence step
    function automatic reg_op_t step_op(step_t s, logic [SPEED_W-1:0] spd);
        reg_op_t o;
        o.addr = GCTL_ADDR;
        o.mask = '0;
        o.val  = '0;
        o.rmw  = 1'b1;
        case (s)
            STEP_TRAIN_OFF: begin
                o.mask[TRAIN_EN_BIT] = 1'b1;
            end
            STEP_DEVTYPE: begin
                o.mask[DEVTYPE_LSB +: DEVTYPE_W] = '1;
                o.val[DEVTYPE_LSB +: DEVTYPE_W]  = DEVTYPE_W'(DEVTYPE_ROOT);
            end
            STEP_RCACHE: begin
                o.addr = RCACHE_ADDR;
                o.mask = '1;
                o.val  = RCACHE_VAL;
                o.rmw  = 1'b0;
            end
            STEP_WCACHE: begin
                o.addr = WCACHE_ADDR;
                o.mask = '1;
                o.val  = WCACHE_VAL;
                o.rmw  = 1'b0;
            end
            STEP_LCTL2: begin
                o.addr = LCTL2_ADDR;
                o.mask[SPEED_W-1:0] = '1;
                o.val[SPEED_W-1:0]  = spd;
            end
            STEP_LCAP: begin
                o.addr = LCAP_ADDR;
                o.mask[SPEED_W-1:0] = '1;
                o.val[SPEED_W-1:0]  = spd;
            end
            STEP_EQ: begin
                o.addr = EQCTL_ADDR;
                o.mask[EQ_EVAL_OFF_BIT] = 1'b1;
                o.val[EQ_EVAL_OFF_BIT]  = 1'b1;
            end
            default: begin  // STEP_TRAIN_ON
                o.mask[TRAIN_EN_BIT] = 1'b1;
                o.val[TRAIN_EN_BIT]  = 1'b1;
            end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lnk_tick_cnt.sv
// Module: lnk_tick_cnt
// Counts external tick pulses while enabled and flags the LIMIT-th one.
// Assumes: ticks are one-cycle pulses; dropping en clears the count.
module lnk_tick_cnt #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Tick counter, cleared whenever disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end

    // Terminal pulse on the LIMIT-th tick
    assign hit = en && tick && (cnt == LAST);

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_clear_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);

endmodule

// File: rtl/lnk_rmw_port.sv
// Module: lnk_rmw_port
// Carries out one register operation at a time on the controller port:
// read, capture, merged write for read-modify-write, or a plain write.
// Assumes: read data is valid in the cycle after cfg_rd_en.
module lnk_rmw_port
    import lnk_bringup_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_go,
    input  reg_op_t   op,
    output logic      op_done,
    output logic      cfg_rd_en,
    output logic      cfg_wr_en,
    output reg_addr_t cfg_addr,
    output reg_data_t cfg_wdata,
    input  reg_data_t cfg_rdata
);
    port_state_t pst;
    reg_op_t     op_q;
    reg_data_t   old_q;

    // Operation state, held operation and captured read value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst   <= P_IDLE;
            op_q  <= '0;
            old_q <= '0;
        end else begin
            case (pst)
                P_IDLE: if (op_go) begin
                    op_q  <= op;
                    old_q <= '0;
                    pst   <= op.rmw ? P_READ : P_WRITE;
                end
                P_READ:  pst <= P_CAPT;
                P_CAPT: begin
                    old_q <= cfg_rdata;
                    pst   <= P_WRITE;
                end
                default: pst <= P_IDLE;
            endcase
        end
    end

    // Port drive and merged write data
    always_comb begin
        cfg_rd_en = (pst == P_READ);
        cfg_wr_en = (pst == P_WRITE);
        cfg_addr  = op_q.addr;
        cfg_wdata = (old_q & ~op_q.mask) | (op_q.val & op_q.mask);
        op_done   = (pst == P_WRITE);
    end

    assert_rw_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd_en && cfg_wr_en));

    assert_read_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && op_q.rmw) |-> $past(cfg_rd_en, 2));

    assert_go_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |-> pst == P_IDLE);

endmodule

// File: rtl/lnk_seq_ctrl.sv
// Module: lnk_seq_ctrl
// Step controller: walks the configuration steps, skips the training
// enable steps when the link is already up, then polls and settles.
// Assumes: link_ok is synchronous to clk; hits come from lnk_tick_cnt.
module lnk_seq_ctrl
    import lnk_bringup_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SPEED_W-1:0] speed_code,
    input  logic               link_ok,
    input  logic               op_done,
    input  logic               ms_hit,
    input  logic               us_hit,
    output logic               op_go,
    output reg_op_t            op,
    output logic               ms_en,
    output logic               us_en,
    output logic               done,
    output logic               link_up,
    output logic               timeout
);
    seq_state_t         st;
    step_t              step;
    logic [SPEED_W-1:0] spd_q;
    logic               skip_now;

    // Training enable steps are skipped while the link is already up
    assign skip_now = link_ok && (step == STEP_TRAIN_OFF || step == STEP_TRAIN_ON);

    // Main sequencing state and outcome registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            step    <= STEP_TRAIN_OFF;
            spd_q   <= '0;
            done    <= 1'b0;
            link_up <= 1'b0;
            timeout <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    spd_q   <= speed_code;
                    step    <= STEP_TRAIN_OFF;
                    done    <= 1'b0;
                    link_up <= 1'b0;
                    timeout <= 1'b0;
                    st      <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (skip_now) begin
                        if (step == STEP_TRAIN_ON) st <= ST_POLL;
                        else step <= step_t'(step + 3'd1);
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: if (op_done) begin
                    if (step == STEP_TRAIN_ON) begin
                        st <= ST_POLL;
                    end else begin
                        step <= step_t'(step + 3'd1);
                        st   <= ST_ISSUE;
                    end
                end
                ST_POLL: begin
                    if (link_ok) begin
                        st <= ST_SETTLE;
                    end else if (ms_hit) begin
                        done    <= 1'b1;
                        timeout <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
                ST_SETTLE: if (us_hit) begin
                    done    <= 1'b1;
                    link_up <= 1'b1;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Operation request and counter enables
    always_comb begin
        op_go = (st == ST_ISSUE) && !skip_now;
        op    = step_op(step, spd_q);
        ms_en = (st == ST_POLL);
        us_en = (st == ST_SETTLE);
    end

    assert_outcome_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && timeout));

    assert_done_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> st == ST_IDLE);

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> !(st == ST_ISSUE && step == STEP_TRAIN_OFF));

    assert_poll_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POLL && link_ok) |=> st == ST_SETTLE);

    assert_timeout_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POLL && !link_ok && ms_hit) |=> (timeout && done && !link_up));

    assert_settle_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE && us_hit) |=> (link_up && done));

endmodule

// File: rtl/lnk_bringup_seq.sv
// Module: lnk_bringup_seq (top)
// Root-port link bring-up sequencer: configures the controller through a
// register port, then waits for link-up under a millisecond-tick timeout
// followed by a microsecond-tick settle delay.
// Assumes: link_status and cfg_rdata are synchronous to clk.
module lnk_bringup_seq
    import lnk_bringup_pkg::*;
#(
    parameter int TIMEOUT_MS = 100,
    parameter int SETTLE_US  = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SPEED_W-1:0] speed_code,
    input  logic               tick_ms,
    input  logic               tick_us,
    input  logic [DATA_W-1:0]  link_status,
    output logic               cfg_rd_en,
    output logic               cfg_wr_en,
    output logic [ADDR_W-1:0]  cfg_addr,
    output logic [DATA_W-1:0]  cfg_wdata,
    input  logic [DATA_W-1:0]  cfg_rdata,
    output logic               done,
    output logic               link_up,
    output logic               timeout
);
    logic    link_ok;
    logic    op_go, op_done;
    reg_op_t op;
    logic    ms_en, us_en, ms_hit, us_hit;
    logic    unused_sts;

    // Link counts as up only with both layer indications present
    assign link_ok    = link_status[STS_DL_BIT] & link_status[STS_PHY_BIT];
    assign unused_sts = ^link_status;

    lnk_seq_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .speed_code (speed_code),
        .link_ok    (link_ok),
        .op_done    (op_done),
        .ms_hit     (ms_hit),
        .us_hit     (us_hit),
        .op_go      (op_go),
        .op         (op),
        .ms_en      (ms_en),
        .us_en      (us_en),
        .done       (done),
        .link_up    (link_up),
        .timeout    (timeout)
    );

    lnk_rmw_port i_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_go     (op_go),
        .op        (op),
        .op_done   (op_done),
        .cfg_rd_en (cfg_rd_en),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata)
    );

    lnk_tick_cnt #(.LIMIT(TIMEOUT_MS)) i_ms_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ms_en),
        .tick  (tick_ms),
        .hit   (ms_hit)
    );

    lnk_tick_cnt #(.LIMIT(SETTLE_US)) i_us_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (us_en),
        .tick  (tick_us),
        .hit   (us_hit)
    );

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !start) |-> !(cfg_rd_en || cfg_wr_en));

    assert_linkup_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up || timeout) |-> done);

endmodule

// File: tb/test_lnk_bringup_seq.sv
// Scoreboard bench: the driver pushes expected writes, a monitor pops and
// compares them against the register port; outcome checks in the tasks.
module test_lnk_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  speed_code = 4'd0;
    logic        tick_ms = 1'b0;
    logic        tick_us = 1'b0;
    logic [31:0] link_status = 32'd0;
    logic        cfg_rd_en, cfg_wr_en;
    logic [15:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = 32'd0;
    logic        done, link_up, timeout;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] mem [logic [15:0]];
    logic [15:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_bringup_seq i_lnk_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .speed_code(speed_code),
        .tick_ms(tick_ms), .tick_us(tick_us), .link_status(link_status),
        .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .done(done), .link_up(link_up), .timeout(timeout)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] a, input logic [31:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // Monitor: register model plus scoreboard compare on every write
    always @(negedge clk) begin
        if (cfg_rd_en) cfg_rdata <= mem.exists(cfg_addr) ? mem[cfg_addr] : 32'd0;
        if (cfg_wr_en) begin
            if (q_addr.size() == 0) begin
                chk(1'b0, "R11 unexpected write", {16'd0, cfg_addr}, 32'd0);
            end else begin
                logic [15:0] ea;
                logic [31:0] ed;
                string       et;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                chk(cfg_addr == ea, {et, " address (R12 order)"}, {16'd0, cfg_addr}, {16'd0, ea});
                chk(cfg_wdata == ed, {et, " data"}, cfg_wdata, ed);
            end
            mem[cfg_addr] = cfg_wdata;
        end
    end

    // Watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles >= WDOG_LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic preload();
        mem[16'h8000] = 32'hA5A5_5A5F;   // bit 2 set, type field 5
        mem[16'h8050] = 32'hFFFF_FFFF;
        mem[16'h8054] = 32'h0000_0000;
        mem[16'h00A0] = 32'hDEAD_BEEF;
        mem[16'h007C] = 32'h1234_567A;
        mem[16'h08A8] = 32'hF0F0_F0DF;   // bit 5 clear
    endtask

    // Driver: compute expected write list, then pulse start
    task automatic begin_seq(input bit up, input logic [3:0] spd);
        logic [31:0] c;
        preload();
        c = mem[16'h8000];
        if (!up) begin
            c = c & ~32'h4;
            push_exp(16'h8000, c, "R3");
        end
        c = (c & ~32'hF0) | 32'h40;
        push_exp(16'h8000, c, "R4");
        push_exp(16'h8050, 32'h0000_3511, "R5");
        push_exp(16'h8054, 32'h0000_5311, "R5");
        push_exp(16'h00A0, (mem[16'h00A0] & ~32'hF) | {28'd0, spd}, "R6");
        push_exp(16'h007C, (mem[16'h007C] & ~32'hF) | {28'd0, spd}, "R6");
        push_exp(16'h08A8, mem[16'h08A8] | 32'h20, "R7");
        if (!up) push_exp(16'h8000, c | 32'h4, "R8");
        @(negedge clk);
        speed_code = spd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        speed_code = 4'hF;  // later changes must not matter (R6)
        for (int i = 0; i < 200 && q_addr.size() != 0; i++) @(negedge clk);
        chk(q_addr.size() == 0, "R12 all writes issued", q_addr.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ms(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1; @(negedge clk);
            tick_ms = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_us(input int n);
        for (int i = 0; i < n; i++) begin
            tick_us = 1'b1; @(negedge clk);
            tick_us = 1'b0; @(negedge clk);
        end
    endtask

    task automatic chk_out(input logic d, input logic l, input logic t, input string tag);
        chk({done, link_up, timeout} == {d, l, t}, tag,
            {29'd0, done, link_up, timeout}, {29'd0, d, l, t});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and quiet port
        chk_out(1'b0, 1'b0, 1'b0, "R1 reset outputs");
        chk(!(cfg_rd_en || cfg_wr_en), "R1 port quiet", {31'd0, cfg_wr_en}, 32'd0);

        // Run A: link down at start, speed 3, comes up after some ms ticks
        link_status = 32'd0;
        begin_seq(1'b0, 4'd3);
        pulse_ms(5);
        chk_out(1'b0, 1'b0, 1'b0, "R9 still polling");
        link_status = 32'h0000_0202;
        @(negedge clk);
        pulse_us(99);
        chk_out(1'b0, 1'b0, 1'b0, "R10 settle not finished");
        pulse_us(1);
        chk_out(1'b1, 1'b1, 1'b0, "R10 link up after settle");
        // R11: outcome held with idle stimulus
        pulse_ms(3);
        pulse_us(3);
        chk_out(1'b1, 1'b1, 1'b0, "R11 outcome held");

        // Run B: link already up, speed 1, training steps skipped (R3, R8)
        link_status = 32'h0000_0202;
        begin_seq(1'b1, 4'd1);
        chk_out(1'b0, 1'b0, 1'b0, "R11 start clears outcome");
        pulse_us(100);
        chk_out(1'b1, 1'b1, 1'b0, "R10 up at start");

        // Run C: only data link bit, speed 2 -> timeout (R2, R9)
        link_status = 32'h0000_0002;
        begin_seq(1'b0, 4'd2);
        pulse_ms(99);
        chk_out(1'b0, 1'b0, 1'b0, "R2 one bit not enough / R9 before limit");
        pulse_ms(1);
        chk_out(1'b1, 1'b0, 1'b1, "R9 timeout");

        // Run D: only physical bit, stray start mid-poll ignored (R2, R11)
        link_status = 32'h0000_0200;
        begin_seq(1'b0, 4'd3);
        pulse_ms(40);
        start = 1'b1; @(negedge clk); start = 1'b0;
        pulse_ms(59);
        chk_out(1'b0, 1'b0, 1'b0, "R11 restart ignored / R2 phy bit alone");
        pulse_ms(1);
        chk_out(1'b1, 1'b0, 1'b1, "R9 timeout after ignored start");
        repeat (10) @(negedge clk);
        chk(q_addr.size() == 0, "R11 no extra writes", q_addr.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule